// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block generates the frequency-offset word that steers a fractional-N feedback divider so that a synthesized clock sweeps back and forth between a lower and an upper frequency, spreading its energy over a band. It runs on the reference clock and traces a triangular profile over one modulation period. The period is 128, 256 or 512 reference cycles, chosen by a range select that also names the input-frequency band.

Two spread selects, each carrying an already-decoded three-level value, choose among four center-spread settings, four down-spread settings and a no-spread test setting. A two-bit sub-band input gives the position of the reference frequency within its band. The setting and the sub-band together pick the spread amplitude, which shrinks as the reference frequency rises. An active-low power-down input and the no-spread setting both hold the offset at zero. When the offset is released it starts again from nominal.

Top module: `ssm_profile_gen`

## Requirements
- R1: Every three-level input uses 2'b00 = low, 2'b01 = middle and 2'b10 = high. The code 2'b11 behaves exactly like middle.
- R2: The spread selects (hi, lo) decode as follows, and `mode_o` reports 2'b01 for center, 2'b10 for down and 2'b00 for none. Center settings from widest to narrowest are (L,L), (L,M), (L,H), (M,L). Down settings from widest to narrowest are (H,H), (H,L), (M,H), (H,M). (M,M) is no spread.
- R3: `amp_o` (unit 0.01 %) for sub-bands 0..3 is as follows. Center ranks 0..3: 140/130/120/110, 120/110/90/90, 60/50/50/40 and 50/40/40/30. Down ranks 0..3: 300/270/250/230, 220/190/180/170, 190/170/150/140 and 70/60/60/50. No spread gives 0.
- R4: The modulation period D is 128 cycles for range low, 256 for range high and 512 for range middle. The offset returns to exactly 0 every D cycles.
- R5: In center spread, with A = `amp_o`, q = D/4 and step s = A·2048/D (in 1/512 units), the internal value at phase k is k·s for k ≤ q, (2q−k)·s for q ≤ k ≤ 3q, and (k−D)·s above 3q. `offset_o` is that value divided by 512 and rounded toward minus infinity.
- R6: In down spread, with s = A·1024/D, the value at phase k is −k·s for k ≤ D/2 and (k−D)·s above D/2, with the same scaling. The offset never goes above 0 and reaches −A at mid-period.
- R7: In center spread the offset stays within ±A.
- R8: While `pd_n` is low, the offset is 0 from the next clock edge on. After release, the profile resumes from phase 0, so that one edge after release the phase is 1.
- R9: With the no-spread setting the offset is 0 from the next clock edge on.
- R10: A change of any select or of the sub-band that alters the mode, the period or the amplitude restarts the period: after the next edge the phase is 0.
- R11: Synchronous reset clears the phase and the offset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down |
| range_sel | input | 2 | Input band select (three-level code) |
| amt_sel_hi | input | 2 | Spread select, upper (three-level code) |
| amt_sel_lo | input | 2 | Spread select, lower (three-level code) |
| sub_band | input | 2 | Position of the reference within its band, 0 = lowest quarter |
| mode_o | output | 2 | Decoded spread mode |
| amp_o | output | 9 | Spread amplitude in 0.01 % |
| offset_o | output | 12 | Signed frequency offset in 0.01 % |

## Verification
The bound properties assume that the selects change no more often than once per cycle. They also assume that a change in the selects reaches the ramp before it alters the sign or amplitude limits. This holds because any change in the configuration clears the accumulator at the same edge. The bench keeps within these assumptions by driving every input on the falling edge and holding each configuration for a whole period. It sweeps all sixteen select codes, all four range codes and all four sub-bands. Each sweep passes through a power-down pulse, so every profile starts from a known phase.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int OFS_W    = 12;
    localparam int FRAC_W   = 9;
    localparam int AMP_W    = 9;
    localparam int BASE_LOG = 7;
    localparam int MAX_LOG  = BASE_LOG + 2;
    localparam int PH_W     = MAX_LOG + 1;
    localparam int INC_W    = AMP_W + FRAC_W + 2;
    localparam int ACC_W    = OFS_W + FRAC_W + 1;

    localparam logic [1:0] LVL_LO  = 2'b00;
    localparam logic [1:0] LVL_MID = 2'b01;
    localparam logic [1:0] LVL_HI  = 2'b10;

    typedef enum logic [1:0] {
        SPR_NONE   = 2'b00,
        SPR_CENTER = 2'b01,
        SPR_DOWN   = 2'b10
    } spr_mode_e;

    typedef struct packed {
        spr_mode_e  mode;
        logic [1:0] rank;
    } spr_sel_t;

    typedef struct packed {
        spr_mode_e          mode;
        logic [1:0]         span;
        logic [INC_W-1:0]   inc;
    } ramp_cfg_t;

    function automatic logic [1:0] norm_lvl(input logic [1:0] raw);
        return (raw == 2'b11) ? LVL_MID : raw;
    endfunction

    function automatic spr_sel_t decode_sel(input logic [1:0] hi, input logic [1:0] lo);
        spr_sel_t r;
        r.mode = SPR_NONE;
        r.rank = 2'd0;
        unique case ({hi, lo})
            {LVL_LO,  LVL_LO }: begin r.mode = SPR_CENTER; r.rank = 2'd0; end
            {LVL_LO,  LVL_MID}: begin r.mode = SPR_CENTER; r.rank = 2'd1; end
            {LVL_LO,  LVL_HI }: begin r.mode = SPR_CENTER; r.rank = 2'd2; end
            {LVL_MID, LVL_LO }: begin r.mode = SPR_CENTER; r.rank = 2'd3; end
            {LVL_HI,  LVL_HI }: begin r.mode = SPR_DOWN;   r.rank = 2'd0; end
            {LVL_HI,  LVL_LO }: begin r.mode = SPR_DOWN;   r.rank = 2'd1; end
            {LVL_MID, LVL_HI }: begin r.mode = SPR_DOWN;   r.rank = 2'd2; end
            {LVL_HI,  LVL_MID}: begin r.mode = SPR_DOWN;   r.rank = 2'd3; end
            default:            begin r.mode = SPR_NONE;   r.rank = 2'd0; end
        endcase
        return r;
    endfunction

    function automatic logic [AMP_W-1:0] amp_lookup(input spr_sel_t sel, input logic [1:0] sub);
        logic [AMP_W-1:0] a;
        a = '0;
        if (sel.mode == SPR_CENTER) begin
            unique case ({sel.rank, sub})
                4'h0: a = 9'd140; 4'h1: a = 9'd130; 4'h2: a = 9'd120; 4'h3: a = 9'd110;
                4'h4: a = 9'd120; 4'h5: a = 9'd110; 4'h6: a = 9'd90;  4'h7: a = 9'd90;
                4'h8: a = 9'd60;  4'h9: a = 9'd50;  4'hA: a = 9'd50;  4'hB: a = 9'd40;
                default: begin
                    unique case (sub)
                        2'd0: a = 9'd50;
                        2'd1: a = 9'd40;
                        2'd2: a = 9'd40;
                        default: a = 9'd30;
                    endcase
                end
            endcase
        end else if (sel.mode == SPR_DOWN) begin
            unique case ({sel.rank, sub})
                4'h0: a = 9'd300; 4'h1: a = 9'd270; 4'h2: a = 9'd250; 4'h3: a = 9'd230;
                4'h4: a = 9'd220; 4'h5: a = 9'd190; 4'h6: a = 9'd180; 4'h7: a = 9'd170;
                4'h8: a = 9'd190; 4'h9: a = 9'd170; 4'hA: a = 9'd150; 4'hB: a = 9'd140;
                default: begin
                    unique case (sub)
                        2'd0: a = 9'd70;
                        2'd1: a = 9'd60;
                        2'd2: a = 9'd60;
                        default: a = 9'd50;
                    endcase
                end
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/ssm_decode.sv
module ssm_decode
    import ssm_pkg::*;
(
    input  logic [1:0]       range_sel,
    input  logic [1:0]       amt_sel_hi,
    input  logic [1:0]       amt_sel_lo,
    input  logic [1:0]       sub_band,
    output spr_mode_e        mode,
    output logic [AMP_W-1:0] amp,
    output ramp_cfg_t        cfg
);
    spr_sel_t   sel;
    logic [1:0] rng;
    logic [1:0] span;
    logic [INC_W-1:0] amp_wide;
    logic [INC_W-1:0] scaled;

    always_comb begin
        sel = decode_sel(norm_lvl(amt_sel_hi), norm_lvl(amt_sel_lo));
        rng = norm_lvl(range_sel);
        unique case (rng)
            LVL_LO:  span = 2'd0;
            LVL_HI:  span = 2'd1;
            default: span = 2'd2;
        endcase
        mode     = sel.mode;
        amp      = amp_lookup(sel, sub_band);
        amp_wide = {{(INC_W-AMP_W){1'b0}}, amp};
        // center climbs 2A in half a period, down climbs A in half a period
        if (sel.mode == SPR_CENTER)
            scaled = amp_wide << (FRAC_W + 2);
        else
            scaled = amp_wide << (FRAC_W + 1);
        cfg.mode = sel.mode;
        cfg.span = span;
        cfg.inc  = scaled >> (BASE_LOG + int'(span));
    end
endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp
    import ssm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  ramp_cfg_t               cfg,
    output logic signed [ACC_W-1:0] acc
);
    typedef struct packed {
        logic [PH_W-1:0]         ph;
        logic signed [ACC_W-1:0] acc;
    } ramp_state_t;

    ramp_state_t st;
    ramp_cfg_t   cfg_q;
    logic [PH_W-1:0] dr, quarter, half, three_q;
    logic rising;
    logic restart;
    logic signed [ACC_W-1:0] step;

    always_comb begin
        dr      = PH_W'(1) << (BASE_LOG + int'(cfg.span));
        quarter = dr >> 2;
        half    = dr >> 1;
        three_q = quarter + (quarter << 1);
        if (cfg.mode == SPR_CENTER)
            rising = (st.ph < quarter) || (st.ph >= three_q);
        else
            rising = (st.ph >= half);
        restart = (cfg != cfg_q);
        step    = $signed({{(ACC_W-INC_W){1'b0}}, cfg.inc});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            st    <= '0;
        end else begin
            cfg_q <= cfg;
            if (!run || restart || (st.ph >= dr - PH_W'(1))) begin
                st <= '0;
            end else begin
                st.ph  <= st.ph + PH_W'(1);
                st.acc <= rising ? (st.acc + step) : (st.acc - step);
            end
        end
    end

    assign acc = st.acc;
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_n,
    input  logic [1:0]        range_sel,
    input  logic [1:0]        amt_sel_hi,
    input  logic [1:0]        amt_sel_lo,
    input  logic [1:0]        sub_band,
    output logic [1:0]        mode_o,
    output logic [AMP_W-1:0]  amp_o,
    output logic signed [OFS_W-1:0] offset_o
);
    spr_mode_e mode;
    ramp_cfg_t cfg;
    logic signed [ACC_W-1:0] acc;
    logic run;

    ssm_decode u_dec (
        .range_sel  (range_sel),
        .amt_sel_hi (amt_sel_hi),
        .amt_sel_lo (amt_sel_lo),
        .sub_band   (sub_band),
        .mode       (mode),
        .amp        (amp_o),
        .cfg        (cfg)
    );

    assign run = pd_n && (mode != SPR_NONE);

    ssm_ramp u_ramp (
        .clk (clk),
        .rst (rst),
        .run (run),
        .cfg (cfg),
        .acc (acc)
    );

    assign mode_o   = mode;
    // dropping fraction bits floors toward minus infinity
    assign offset_o = acc[FRAC_W +: OFS_W];
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker
    import ssm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pd_n,
    input logic [1:0]        mode_o,
    input logic [AMP_W-1:0]  amp_o,
    input logic signed [OFS_W-1:0] offset_o
);
    logic signed [OFS_W-1:0] amp_s;
    assign amp_s = $signed({{(OFS_W-AMP_W){1'b0}}, amp_o});

    AST_PD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !pd_n |=> offset_o == '0); // R8

    AST_NOSPREAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        mode_o == SPR_NONE |=> offset_o == '0); // R9

    AST_DOWN_NONPOS: assert property (@(posedge clk) disable iff (rst)
        mode_o == SPR_DOWN |=> offset_o <= 0); // R6

    AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (rst)
        mode_o == SPR_CENTER |=> (offset_o <= $past(amp_s)) && (offset_o >= -$past(amp_s))); // R7

    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11); // R2
endmodule

bind ssm_profile_gen ssm_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .pd_n     (pd_n),
    .mode_o   (mode_o),
    .amp_o    (amp_o),
    .offset_o (offset_o)
);

// File: tb/tb_ssm_profile_gen.sv
module tb_ssm_profile_gen;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic pd_n;
    logic [1:0] range_sel, amt_sel_hi, amt_sel_lo, sub_band;
    logic [1:0] mode_o;
    logic [8:0] amp_o;
    logic signed [11:0] offset_o;

    int checks = 0;
    int errors = 0;

    int ctab [4][4] = '{'{140,130,120,110}, '{120,110,90,90}, '{60,50,50,40}, '{50,40,40,30}};
    int dtab [4][4] = '{'{300,270,250,230}, '{220,190,180,170}, '{190,170,150,140}, '{70,60,60,50}};

    always #(CLK_PERIOD/2) clk = ~clk;

    ssm_profile_gen dut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .range_sel(range_sel),
        .amt_sel_hi(amt_sel_hi), .amt_sel_lo(amt_sel_lo), .sub_band(sub_band),
        .mode_o(mode_o), .amp_o(amp_o), .offset_o(offset_o)
    );

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nrm(input int v);
        return (v == 3) ? 1 : v;
    endfunction

    // R2: expected mode (0 none, 1 center, 2 down) and rank
    function automatic void exp_sel(input int h, input int l, output int md, output int rk);
        int hh = nrm(h);
        int ll = nrm(l);
        md = 0; rk = 0;
        if (hh == 0) begin md = 1; rk = ll; end
        else if (hh == 1 && ll == 0) begin md = 1; rk = 3; end
        else if (hh == 1 && ll == 2) begin md = 2; rk = 2; end
        else if (hh == 2 && ll == 2) begin md = 2; rk = 0; end
        else if (hh == 2 && ll == 0) begin md = 2; rk = 1; end
        else if (hh == 2 && ll == 1) begin md = 2; rk = 3; end
    endfunction

    // R4: period from range code
    function automatic int exp_period(input int r);
        int rr = nrm(r);
        return (rr == 0) ? 128 : (rr == 2) ? 256 : 512;
    endfunction

    // R5/R6: offset at phase k
    function automatic int exp_ofs(input int md, input int a, input int d, input int k);
        int s, v, q;
        q = d / 4;
        if (md == 1) begin
            s = a * 2048 / d;
            if (k <= q) v = k * s;
            else if (k <= 3*q) v = (2*q - k) * s;
            else v = (k - d) * s;
        end else if (md == 2) begin
            s = a * 1024 / d;
            if (k <= d/2) v = -k * s;
            else v = (k - d) * s;
        end else begin
            v = 0;
        end
        return v >>> 9;
    endfunction

    task automatic drive(input int r, input int h, input int l, input int sb);
        range_sel  = 2'(r);
        amt_sel_hi = 2'(h);
        amt_sel_lo = 2'(l);
        sub_band   = 2'(sb);
    endtask

    task automatic run_profile(input int r, input int h, input int l, input int sb);
        int md, rk, a, d;
        string tag;
        exp_sel(h, l, md, rk);
        a = (md == 1) ? ctab[rk][sb] : (md == 2) ? dtab[rk][sb] : 0;
        d = exp_period(r);
        @(negedge clk);
        pd_n = 1'b0;
        drive(r, h, l, sb);
        #1;
        check_int((h == 3 || l == 3) ? "R1 mode" : "R2 mode", int'(mode_o), md);
        check_int("R3 amp", int'(amp_o), a);
        @(negedge clk);
        check_int("R8 held", int'(offset_o), 0);
        pd_n = 1'b1;
        tag = (md == 1) ? "R5 center" : (md == 2) ? "R6 down" : "R9 none";
        for (int k = 1; k <= d + 2; k++) begin
            @(negedge clk);
            if (k == d)
                check_int((r == 3) ? "R1 R4 wrap" : "R4 wrap", int'(offset_o), 0);
            else
                check_int(tag, int'(offset_o), exp_ofs(md, a, d, k % d));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        pd_n = 1'b1;
        drive(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        check_int("R11 reset", int'(offset_o), 0);
        rst = 1'b0;

        for (int r = 0; r < 4; r++)
            for (int h = 0; h < 4; h++)
                for (int l = 0; l < 4; l++)
                    for (int sb = 0; sb < 4; sb++)
                        run_profile(r, h, l, sb);

        // R10: change sub-band mid-period
        run_profile(0, 0, 0, 0);
        repeat (10) @(negedge clk);
        sub_band = 2'd3;
        @(negedge clk);
        check_int("R10 restart", int'(offset_o), 0);
        @(negedge clk);
        check_int("R10 new slope", int'(offset_o), exp_ofs(1, 110, 128, 1));
        @(negedge clk);
        check_int("R10 new slope", int'(offset_o), exp_ofs(1, 110, 128, 2));

        // R8: power-down mid-period, resume from nominal
        repeat (40) @(negedge clk);
        pd_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_int("R8 pd zero", int'(offset_o), 0);
        end
        pd_n = 1'b1;
        @(negedge clk);
        check_int("R8 resume", int'(offset_o), exp_ofs(1, 110, 128, 1));
        @(negedge clk);
        check_int("R8 resume", int'(offset_o), exp_ofs(1, 110, 128, 2));

        // R9: switch to no spread mid-period
        repeat (20) @(negedge clk);
        amt_sel_hi = 2'd1; amt_sel_lo = 2'd1;
        @(negedge clk);
        check_int("R9 none zero", int'(offset_o), 0);
        check_int("R9 amp zero", int'(amp_o), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule